// File: doc/BRIEF.md
# Major Cycle Timing Sequencer

This block is the timing and control generator of a small word-oriented processor. It splits the system clock into major cycles of four ticks. Each tick is two clock periods long, so every strobe edge can fall on a half-tick boundary. The sequencer steps through four major states: fetch, defer, execute and device I/O.

Every major cycle has a read part in ticks 0 and 1 and a write part in ticks 2 and 3. Data read early in a cycle can therefore pass through the datapath and be written back late in the same cycle. This lets read-modify-write work such as auto-increment finish in one major cycle. The block drives the memory output-enable and write-enable strobes and the device read and write strobes. It also gives one enable pulse per tick, a pulse that runs operate-class instructions in the fetch state, and the load and clear controls of the memory address register. A slow peripheral can lengthen the device I/O state by pulling a stretch line low, either in the read part or in the write part of the cycle.

Top module: `mcyc_seq`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it goes high, the outputs are inactive: `mem_oe_n` and `mem_we_n` are 1, `io_rd`, `io_wr`, `opr_en`, `tick_en`, `ma_ld_page`, `ma_ld_off` and `ma_clr` are 0, `tick` and `half` are 0, and `mstate` is fetch. At that second edge, tick 0 (first half) of a fetch cycle begins.
- R2: Outside a stretch, the half-tick position advances by one on every clock, in the order tick 0 half 0, tick 0 half 1, tick 1 half 0 and so on up to tick 3 half 1, so an unstretched major cycle lasts 8 clocks.
- R3: In fetch, defer and execute, `mem_oe_n` is low in tick 0 (both halves) and in the first half of tick 1, and high at all other times.
- R4: `mem_we_n` is low in tick 2 (both halves) and in the first half of tick 3, only in defer when `dec_autoinc` is 1 or in execute when `dec_mem_wr` is 1. The second half of tick 1 is a gap between read and write, and the second half of tick 3 is write hold.
- R5: In the device I/O state, `io_rd` and `io_wr` use the same windows as the memory read and write strobes, and both memory strobes stay high. Outside that state, `io_rd` and `io_wr` are 0.
- R6: In the device I/O state, `stretch_n` low holds the position at tick 0 half 1 or at tick 2 half 1 for that clock, and the active strobe stays asserted. In every other state and position, `stretch_n` has no effect.
- R7: The state changes only at the end of tick 3. The next state is chosen from the decode flags as follows:
  - from fetch: defer if `dec_memref` and `dec_indirect` are both 1; otherwise execute if `dec_memref` is 1; otherwise device I/O if `dec_devio` is 1; otherwise fetch;
  - from defer: execute;
  - from execute or device I/O: fetch.
  - The encoding is fetch=0, defer=1, execute=2, device I/O=3.
- R8: `opr_en` is 1 for exactly one clock, in the first half of tick 2 of a fetch cycle, when `dec_memref` and `dec_devio` are both 0.
- R9: In the second half of tick 3, the address register controls depend on the transition:
  - next state fetch, or defer to execute: `ma_ld_page` and `ma_ld_off` are both 1;
  - fetch to defer or to execute: `ma_ld_off` is 1, and `ma_clr` equals the inverse of `dec_curpage`;
  - at all other times: all three are 0.
  - `ma_clr` and `ma_ld_page` are never 1 together.
- R10: `tick_en[i]` is 1 only in the first half of tick i, so `tick_en` is one-hot or zero. Under a stretch it pulses only once per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (two clocks per tick) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stretch_n | input | 1 | Active-low request from a slow device to stretch the I/O state |
| dec_indirect | input | 1 | Current instruction uses indirect addressing |
| dec_autoinc | input | 1 | Indirect pointer is an auto-increment location |
| dec_memref | input | 1 | Current instruction references memory |
| dec_mem_wr | input | 1 | Execute state writes memory |
| dec_devio | input | 1 | Current instruction addresses an external device |
| dec_curpage | input | 1 | Operand lies in the current page (otherwise page zero) |
| tick | output | 2 | Current tick within the major cycle |
| half | output | 1 | Second half of the current tick |
| mstate | output | 2 | Major state: 0 fetch, 1 defer, 2 execute, 3 device I/O |
| tick_en | output | 4 | One-hot enable in the first half of each tick |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| opr_en | output | 1 | Execute pulse for operate-class and CPU-internal instructions |
| ma_ld_page | output | 1 | Load the page field of the address register |
| ma_ld_off | output | 1 | Load the offset field of the address register |
| ma_clr | output | 1 | Clear the page field of the address register |

## Verification
The properties assume that the decode flags stay stable through each major cycle. The bench respects this by changing them only in the first half of tick 0. This is after the state decision has been taken and before any strobe or pulse reads them. The properties also assume that `stretch_n` is synchronous to the clock. The bench drives it on the falling edge, with a high rate of low values, in every state and position. This exercises both the stretch windows in the device I/O state and the cases where the line must be ignored, including one long stretch held low for hundreds of clocks.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [1:0] {
    MS_FETCH = 2'd0,
    MS_DEFER = 2'd1,
    MS_EXEC  = 2'd2,
    MS_IO    = 2'd3
  } mstate_e;
endpackage

// File: rtl/mcyc_phase.sv
// Half-tick phase counter with I/O stretch hold.
module mcyc_phase #(
  parameter int TICKS = 4,
  localparam int NPH = TICKS * 2,
  localparam int PHW = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           in_io,
  input  logic           stretch_n,
  output logic [PHW-1:0] ph,
  output logic           cyc_end
);
  localparam logic [PHW-1:0] RD_HOLD = PHW'(1);
  localparam logic [PHW-1:0] WR_HOLD = PHW'(TICKS + 1);
  localparam logic [PHW-1:0] LAST    = PHW'(NPH - 1);

  logic           hold;
  logic [PHW-1:0] ph_nxt;

  always_comb begin
    hold    = in_io && !stretch_n && (ph == RD_HOLD || ph == WR_HOLD);
    cyc_end = run && (ph == LAST);
    ph_nxt  = ph;
    if (run && !hold) begin
      if (ph == LAST) ph_nxt = '0;
      else            ph_nxt = ph + PHW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_nxt;
  end
endmodule

// File: rtl/mcyc_fsm.sv
// Major state register and next-state selection.
module mcyc_fsm
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cyc_end,
  input  logic    indirect,
  input  logic    memref,
  input  logic    devio,
  output mstate_e state,
  output mstate_e nxt
);
  always_comb begin
    nxt = MS_FETCH;
    unique case (state)
      MS_FETCH: begin
        if (memref && indirect) nxt = MS_DEFER;
        else if (memref)        nxt = MS_EXEC;
        else if (devio)         nxt = MS_IO;
        else                    nxt = MS_FETCH;
      end
      MS_DEFER: nxt = MS_EXEC;
      MS_EXEC:  nxt = MS_FETCH;
      MS_IO:    nxt = MS_FETCH;
      default:  nxt = MS_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= MS_FETCH;
    else if (cyc_end) state <= nxt;
  end
endmodule

// File: rtl/mcyc_strobe.sv
// Strobe windows, tick enables, operate pulse and address register controls.
module mcyc_strobe
  import mcyc_pkg::*;
#(
  parameter int TICKS = 4,
  localparam int NPH = TICKS * 2,
  localparam int PHW = $clog2(NPH)
) (
  input  logic             run,
  input  logic [PHW-1:0]   ph,
  input  logic             cyc_end,
  input  mstate_e          state,
  input  mstate_e          nxt,
  input  logic             autoinc,
  input  logic             mem_wr,
  input  logic             memref,
  input  logic             devio,
  input  logic             curpage,
  output logic [TICKS-1:0] tick_en,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             io_rd,
  output logic             io_wr,
  output logic             opr_en,
  output logic             ma_ld_page,
  output logic             ma_ld_off,
  output logic             ma_clr
);
  localparam logic [PHW-1:0] RD_LAST  = PHW'(TICKS - 2);
  localparam logic [PHW-1:0] WR_FIRST = PHW'(TICKS);
  localparam logic [PHW-1:0] WR_LAST  = PHW'(NPH - 2);
  localparam logic [PHW-1:0] OPR_PH   = PHW'(TICKS);

  logic rd_win, wr_win, mem_acc, wr_ok;

  for (genvar i = 0; i < TICKS; i++) begin : g_tick_en
    assign tick_en[i] = run && (ph == PHW'(2 * i));
  end

  always_comb begin
    rd_win   = run && (ph <= RD_LAST);
    wr_win   = run && (ph >= WR_FIRST) && (ph <= WR_LAST);
    mem_acc  = (state != MS_IO);
    wr_ok    = (state == MS_DEFER && autoinc) || (state == MS_EXEC && mem_wr);
    mem_oe_n = !(rd_win && mem_acc);
    mem_we_n = !(wr_win && mem_acc && wr_ok);
    io_rd    = rd_win && (state == MS_IO);
    io_wr    = wr_win && (state == MS_IO);
    opr_en   = run && (state == MS_FETCH) && (ph == OPR_PH) && !memref && !devio;

    ma_ld_page = 1'b0;
    ma_ld_off  = 1'b0;
    ma_clr     = 1'b0;
    if (cyc_end) begin
      if (nxt == MS_FETCH || (state == MS_DEFER && nxt == MS_EXEC)) begin
        ma_ld_page = 1'b1;
        ma_ld_off  = 1'b1;
      end else if (state == MS_FETCH && (nxt == MS_DEFER || nxt == MS_EXEC)) begin
        ma_ld_off = 1'b1;
        ma_clr    = !curpage;
      end
    end
  end
endmodule

// File: rtl/mcyc_seq.sv
// Top: reset release synchronizer and sequencer sub-blocks.
module mcyc_seq
  import mcyc_pkg::*;
#(
  parameter int TICKS = 4,
  localparam int NPH = TICKS * 2,
  localparam int PHW = $clog2(NPH),
  localparam int TW  = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stretch_n,
  input  logic             dec_indirect,
  input  logic             dec_autoinc,
  input  logic             dec_memref,
  input  logic             dec_mem_wr,
  input  logic             dec_devio,
  input  logic             dec_curpage,
  output logic [TW-1:0]    tick,
  output logic             half,
  output logic [1:0]       mstate,
  output logic [TICKS-1:0] tick_en,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             io_rd,
  output logic             io_wr,
  output logic             opr_en,
  output logic             ma_ld_page,
  output logic             ma_ld_off,
  output logic             ma_clr
);
  logic [1:0]     rst_sync;
  logic           run;
  logic [PHW-1:0] ph;
  logic           cyc_end;
  mstate_e        state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  mcyc_phase #(.TICKS(TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .in_io(state == MS_IO),
    .stretch_n(stretch_n), .ph(ph), .cyc_end(cyc_end)
  );

  mcyc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .indirect(dec_indirect),
    .memref(dec_memref), .devio(dec_devio), .state(state), .nxt(nxt)
  );

  mcyc_strobe #(.TICKS(TICKS)) u_strobe (
    .run(run), .ph(ph), .cyc_end(cyc_end), .state(state), .nxt(nxt),
    .autoinc(dec_autoinc), .mem_wr(dec_mem_wr), .memref(dec_memref),
    .devio(dec_devio), .curpage(dec_curpage), .tick_en(tick_en),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .io_rd(io_rd), .io_wr(io_wr),
    .opr_en(opr_en), .ma_ld_page(ma_ld_page), .ma_ld_off(ma_ld_off),
    .ma_clr(ma_clr)
  );

  assign tick   = ph[PHW-1:1];
  assign half   = ph[0];
  assign mstate = state;
endmodule

// File: rtl/mcyc_chk.sv
// Property checker attached to the sequencer top.
module mcyc_chk #(
  parameter int TICKS = 4,
  localparam int TW = $clog2(TICKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stretch_n,
  input logic [TW-1:0]    tick,
  input logic             half,
  input logic [1:0]       mstate,
  input logic [TICKS-1:0] tick_en,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             opr_en,
  input logic             ma_ld_page,
  input logic             ma_clr
);
  localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);
  localparam logic [TW-1:0] OPR_T  = TW'(TICKS / 2);

  // R4
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R5
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 2'd3) |-> (mem_oe_n && mem_we_n));

  // R2
  half_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en != '0) |=> (half && $stable(tick)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 2'd3 && !stretch_n && tick == '0 && half) |=> (tick == '0 && half));

  // R7
  state_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mstate) |-> ($past(tick) == LAST_T && $past(half)));

  // R8
  opr_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opr_en |-> (mstate == 2'd0 && tick == OPR_T && !half));

  // R9
  ma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ma_clr && ma_ld_page));

  // R10
  tick_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tick_en));
endmodule

bind mcyc_seq mcyc_chk #(.TICKS(TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stretch_n(stretch_n), .tick(tick), .half(half),
  .mstate(mstate), .tick_en(tick_en), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .opr_en(opr_en), .ma_ld_page(ma_ld_page), .ma_clr(ma_clr)
);

// File: tb/mcyc_seq_tb.sv
`timescale 1ns/1ps
module mcyc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stretch_n = 1'b1;
  logic d_ind = 0, d_ainc = 0, d_mref = 0, d_mwr = 0, d_dev = 0, d_cpg = 0;
  logic [1:0] tick;
  logic half;
  logic [1:0] mstate;
  logic [3:0] tick_en;
  logic mem_oe_n, mem_we_n, io_rd, io_wr, opr_en, ma_ld_page, ma_ld_off, ma_clr;

  int checks = 0, errors = 0;
  int m_ph = 0, m_st = 0, m_sync = 0;
  int cyc_wait;

  always #2.5 clk = ~clk;

  mcyc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stretch_n(stretch_n), .dec_indirect(d_ind),
    .dec_autoinc(d_ainc), .dec_memref(d_mref), .dec_mem_wr(d_mwr),
    .dec_devio(d_dev), .dec_curpage(d_cpg), .tick(tick), .half(half),
    .mstate(mstate), .tick_en(tick_en), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .io_rd(io_rd), .io_wr(io_wr), .opr_en(opr_en),
    .ma_ld_page(ma_ld_page), .ma_ld_off(ma_ld_off), .ma_clr(ma_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Next major state from the transition rules (R7).
  function automatic int next_state(input int st);
    if (st == 0) begin
      if (d_mref && d_ind) return 1;
      if (d_mref)          return 2;
      if (d_dev)           return 3;
      return 0;
    end
    if (st == 1) return 2;
    return 0;
  endfunction

  task automatic compare();
    bit run = (m_sync == 2);
    bit rdw = run && m_ph <= 2;
    bit wrw = run && m_ph >= 4 && m_ph <= 6;
    bit wok = (m_st == 1 && d_ainc) || (m_st == 2 && d_mwr);
    int nx = next_state(m_st);
    bit end_c = run && m_ph == 7;
    int e_pg = 0, e_off = 0, e_clr = 0;
    if (end_c) begin
      if (nx == 0 || (m_st == 1 && nx == 2)) begin e_pg = 1; e_off = 1; end
      else if (m_st == 0 && (nx == 1 || nx == 2)) begin e_off = 1; e_clr = !d_cpg; end
    end
    check("R2 tick", tick, run ? m_ph / 2 : 0);
    check("R2 half", half, run ? m_ph % 2 : 0);
    check("R7 mstate", mstate, m_st);
    check("R3 mem_oe_n", mem_oe_n, !(rdw && m_st != 3));
    check("R4 mem_we_n", mem_we_n, !(wrw && m_st != 3 && wok));
    check("R5 io_rd", io_rd, rdw && m_st == 3);
    check("R5 io_wr", io_wr, wrw && m_st == 3);
    check("R10 tick_en", tick_en, (run && m_ph % 2 == 0) ? (1 << (m_ph / 2)) : 0);
    check("R8 opr_en", opr_en, run && m_st == 0 && m_ph == 4 && !d_mref && !d_dev);
    check("R9 ma_ld_page", ma_ld_page, e_pg);
    check("R9 ma_ld_off", ma_ld_off, e_off);
    check("R9 ma_clr", ma_clr, e_clr);
  endtask

  task automatic advance_model();
    if (!rst_n) begin
      m_sync = 0; m_ph = 0; m_st = 0;
    end else begin
      if (m_sync == 2) begin
        bit hold = (m_st == 3) && !stretch_n && (m_ph == 1 || m_ph == 5);
        if (!hold) begin
          if (m_ph == 7) begin m_st = next_state(m_st); m_ph = 0; end
          else m_ph++;
        end
      end
      if (m_sync < 2) m_sync++;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0801));
    // R1: outputs held inactive during reset and synchronizer release
    repeat (3) @(negedge clk);
    #1 compare();
    rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk);
      advance_model();
      @(negedge clk);
      if (c == 2000) begin
        rst_n = 1'b0; // R1: mid-run reset
        m_sync = 0; m_ph = 0; m_st = 0;
      end
      if (c == 2004) rst_n = 1'b1;
      if (m_ph == 0) begin
        int sel = $urandom_range(0, 9);
        d_ind  = $urandom_range(0, 1);
        d_ainc = $urandom_range(0, 1);
        d_mwr  = $urandom_range(0, 1);
        d_cpg  = $urandom_range(0, 1);
        d_mref = (sel < 5);
        d_dev  = (sel >= 3 && sel < 8);
      end
      // R6: a long directed stretch, else frequent random low
      if (c >= 1000 && c < 1300) stretch_n = 1'b0;
      else stretch_n = ($urandom_range(0, 2) != 0);
      #1 compare();
    end
    // R6: directed write-half stretch in the I/O state
    d_mref = 0; d_dev = 1; stretch_n = 1'b1;
    cyc_wait = 0;
    while (!(m_st == 3 && m_ph == 5) && cyc_wait < 64) begin
      @(posedge clk); advance_model(); @(negedge clk);
      if (m_ph == 0) begin d_mref = 0; d_dev = 1; end
      cyc_wait++;
    end
    check("R6 reached write stretch point", m_st * 8 + m_ph, 3 * 8 + 5);
    stretch_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); advance_model(); @(negedge clk);
      #1 compare();
      check("R6 io_wr held", io_wr, 1);
    end
    stretch_n = 1'b1;
    @(posedge clk); advance_model(); @(negedge clk);
    #1 compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule